// File: doc/BRIEF.md
# Weighted-Priority Round-Robin Arbiter

This block shares one resource among four requesting channels, numbered 1 to 4. Normally it hands out the resource in rotation. Channels 3 and 4 each also carry an 8-bit limit on how often they may lose arbitration. A weighted channel that has lost that many times is escalated: it wins the next decision ahead of the rotation. Setting both limits to zero turns escalation off, which leaves plain rotation. If only one limit is zero, that zero stands for 256 losses.

Each arbitrated resource gets its own instance with its own pair of limits, for example one for execution-unit access and one for the shared bus path. Requests are sampled on every rising clock edge. The winner appears on the registered one-hot grant one cycle later, with a valid strobe beside it.

The decision logic is a small state machine with three named states:

- `ST_IDLE`: no channel was granted.
- `ST_ROTATE`: the last grant came from the rotation.
- `ST_ESCALATE`: the last grant went to an escalated channel.

Every decision moves the machine into the state that names how that decision was made, from any state:

- **none-requesting** leads to `ST_IDLE`.
- **rotation-pick** leads to `ST_ROTATE`.
- **escalation-pick** leads to `ST_ESCALATE`.

Reset forces `ST_IDLE`. The valid strobe is high in every state except `ST_IDLE`.

Top module: `wprr_arbiter`

## Requirements
- R1: A synchronous reset, active high, clears the grant and the valid strobe, clears both loss counters and sets the rotation start to channel 1. After reset, with all four channels requesting, the first grant goes to channel 1.
- R2: The grant is registered and is all-zero or one-hot. Bit 0 is channel 1 and bit 3 is channel 4. A grant only goes to a channel whose request was high at the sampling edge that made the decision. The valid strobe is high exactly when the grant is non-zero.
- R3: When both limits are zero, no channel is ever escalated. The grant goes to the first requesting channel found by searching upward from the rotation start, wrapping from channel 4 to channel 1.
- R4: A weighted channel (channel 3 or 4) counts one loss on each decision in which it requests and another channel is granted. The count stops once it equals the effective limit.
- R5: A weighted channel whose loss count has reached its effective limit, and which still requests, wins the next decision ahead of the rotation. Winning clears its count.
- R6: When exactly one limit is zero, that channel's effective limit is 256 losses. A non-zero limit is used as written.
- R7: If channels 3 and 4 are both escalated in the same decision, channel 3 wins. Channel 4 stays escalated and wins the following decision if it still requests.
- R8: A weighted channel's loss count clears on any decision in which that channel is not requesting.
- R9: After every grant, whether it came from the rotation or from escalation, the rotation start moves to the channel after the one granted.
- R10: A decision with no request gives no grant and leaves the rotation start unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | NCH (4) | Request per channel, bit 0 = channel 1 |
| limit_c3 | input | TW (8) | Loss limit of channel 3 (0 = see R3/R6) |
| limit_c4 | input | TW (8) | Loss limit of channel 4 (0 = see R3/R6) |
| grant | output | NCH (4) | Registered one-hot grant |
| grant_vld | output | 1 | High while grant is non-zero |

## Verification
A loss counter that is wrong shows at the ports as an escalated grant. That grant arrives either one or more decisions early or not at all where the rotation would have served another channel. It becomes visible on the first decision after the count reaches its limit.

A misplaced rotation start shows on the very next rotation decision as a grant to the wrong requester. A bench model that follows the requirements therefore compares every cycle over swept limit pairs and request patterns. This catches both kinds of fault within a few cycles of their cause. The 256-loss case needs 257 decisions to expose.

// File: rtl/wprr_pkg.sv
package wprr_pkg;

    // How the most recent arbitration decision was made.
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ROTATE   = 2'd1,
        ST_ESCALATE = 2'd2
    } arb_state_t;

    // Number of channels that carry a loss limit (the two highest channels).
    localparam int unsigned WEIGHTED_CH = 2;

endpackage

// File: rtl/wprr_rr_pick.sv
// Rotation search: first requester at or after the start pointer, with wrap.
module wprr_rr_pick #(
    parameter int unsigned NCH = 4,
    localparam int unsigned PW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] req_i,
    input  logic [PW-1:0]  ptr_i,
    output logic [NCH-1:0] pick_o
);

    always_comb begin
        logic found;
        found  = 1'b0;
        pick_o = '0;
        for (int i = 0; i < NCH; i++) begin
            int idx;
            idx = (int'(ptr_i) + i) % NCH;
            if (!found && req_i[idx]) begin
                pick_o[idx] = 1'b1;
                found       = 1'b1;
            end
        end
    end

endmodule

// File: rtl/wprr_denial_ctr.sv
// Loss counter of one weighted channel; raises escalation at its limit.
module wprr_denial_ctr #(
    parameter int unsigned TW = 8,
    localparam int unsigned CW = TW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          weight_en_i,
    input  logic [TW-1:0] limit_i,
    input  logic          req_i,
    input  logic          won_i,
    input  logic          lost_i,
    output logic          raise_o
);

    // A zero limit, while the other limit is non-zero, means 2**TW losses.
    localparam logic [CW-1:0] ZERO_AS = {1'b1, {TW{1'b0}}};

    logic [CW-1:0] eff_lim;
    logic [CW-1:0] cnt_q;

    assign eff_lim = (limit_i == '0) ? ZERO_AS : {1'b0, limit_i};
    assign raise_o = weight_en_i && req_i && (cnt_q >= eff_lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!weight_en_i || !req_i || won_i) begin
            cnt_q <= '0;
        end else if (lost_i && (cnt_q < eff_lim)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/wprr_arbiter.sv
// Four-way rotation arbiter; the two top channels escalate after a number of losses.
module wprr_arbiter
    import wprr_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned TW  = 8,
    localparam int unsigned PW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] req,
    input  logic [TW-1:0]  limit_c3,
    input  logic [TW-1:0]  limit_c4,
    output logic [NCH-1:0] grant,
    output logic           grant_vld
);

    localparam int unsigned FIRST_W = NCH - WEIGHTED_CH;

    logic [TW-1:0]          lim [WEIGHTED_CH];
    logic [WEIGHTED_CH-1:0] raise;
    logic                   weight_en;
    logic [NCH-1:0]         rr_pick;
    logic [NCH-1:0]         gnt_d;
    logic [PW-1:0]          ptr_q;
    logic [PW-1:0]          ptr_d;
    arb_state_t             state_q;
    arb_state_t             state_d;

    assign lim[0]    = limit_c3;
    assign lim[1]    = limit_c4;
    assign weight_en = (limit_c3 != '0) || (limit_c4 != '0);

    wprr_rr_pick #(.NCH(NCH)) u_pick (
        .req_i  (req),
        .ptr_i  (ptr_q),
        .pick_o (rr_pick)
    );

    for (genvar w = 0; w < WEIGHTED_CH; w++) begin : g_wt
        wprr_denial_ctr #(.TW(TW)) u_ctr (
            .clk         (clk),
            .rst         (rst),
            .weight_en_i (weight_en),
            .limit_i     (lim[w]),
            .req_i       (req[FIRST_W + w]),
            .won_i       (gnt_d[FIRST_W + w]),
            .lost_i      ((gnt_d != '0) && !gnt_d[FIRST_W + w]),
            .raise_o     (raise[w])
        );
    end

    // Decision: escalated channel 3, then escalated channel 4, then rotation.
    always_comb begin
        gnt_d   = '0;
        state_d = ST_IDLE;
        if (raise[0]) begin
            gnt_d[FIRST_W] = 1'b1;
            state_d        = ST_ESCALATE;
        end else if (raise[1]) begin
            gnt_d[FIRST_W + 1] = 1'b1;
            state_d            = ST_ESCALATE;
        end else if (rr_pick != '0) begin
            gnt_d   = rr_pick;
            state_d = ST_ROTATE;
        end
    end

    // Rotation start moves past whichever channel was granted.
    always_comb begin
        ptr_d = ptr_q;
        for (int i = 0; i < NCH; i++) begin
            if (gnt_d[i]) begin
                ptr_d = (i == NCH - 1) ? '0 : PW'(i + 1);
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // Outputs.
    always_ff @(posedge clk) begin
        if (rst) begin
            grant <= '0;
        end else begin
            grant <= gnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:     grant_vld = 1'b0;
            ST_ROTATE:   grant_vld = 1'b1;
            ST_ESCALATE: grant_vld = 1'b1;
            default:     grant_vld = 1'b0;
        endcase
    end

endmodule

// File: rtl/wprr_arbiter_chk.sv
module wprr_arbiter_chk #(
    parameter int unsigned NCH = 4,
    parameter int unsigned TW  = 8
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] req,
    input logic [TW-1:0]  limit_c3,
    input logic [TW-1:0]  limit_c4,
    input logic [NCH-1:0] grant,
    input logic           grant_vld,
    input logic [1:0]     raise
);

    AST_RESET_CLEARS: assert property (@(posedge clk) $past(rst) |-> (grant == '0 && !grant_vld)); // R1
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(grant)); // R2
    AST_VALID_TRACKS: assert property (@(posedge clk) disable iff (rst) grant_vld == (grant != '0)); // R2
    AST_GRANT_HAD_REQ: assert property (@(posedge clk) disable iff (rst) (grant != '0) |-> ((grant & ~$past(req)) == '0)); // R2
    AST_PURE_NO_RAISE: assert property (@(posedge clk) disable iff (rst) (limit_c3 == '0 && limit_c4 == '0) |-> (raise == 2'b00)); // R3
    AST_ESCALATE_WINS: assert property (@(posedge clk) disable iff (rst) raise[0] |=> grant[NCH-2]); // R5
    AST_TIE_C3_FIRST: assert property (@(posedge clk) disable iff (rst) (raise == 2'b11) |=> (grant[NCH-2] && !grant[NCH-1])); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) (req == '0) |=> (grant == '0)); // R10

endmodule

bind wprr_arbiter wprr_arbiter_chk #(.NCH(NCH), .TW(TW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .limit_c3  (limit_c3),
    .limit_c4  (limit_c4),
    .grant     (grant),
    .grant_vld (grant_vld),
    .raise     (raise)
);

// File: tb/wprr_arbiter_test.sv
module wprr_arbiter_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] req = '0;
    logic [7:0] lim3 = '0;
    logic [7:0] lim4 = '0;
    logic [3:0] grant;
    logic       grant_vld;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state (index 0 = channel 3, 1 = channel 4).
    int m_ptr = 0;
    int m_cnt [2];
    logic [3:0] m_exp;
    logic [3:0] last_g;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    wprr_arbiter #(.NCH(4), .TW(8)) uut (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .limit_c3  (lim3),
        .limit_c4  (lim4),
        .grant     (grant),
        .grant_vld (grant_vld)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp_g,
                         input logic act_v, input logic exp_v);
        checks++;
        if (act !== exp_g || act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: grant=%b vld=%b, expected grant=%b vld=%b", tag, act, act_v, exp_g, exp_v);
        end
    endtask

    task automatic model_step(input logic [3:0] r, output logic [3:0] g, output string tag);
        bit on;
        bit r3;
        bit r4;
        int e [2];
        int w;
        on   = (lim3 != 0) || (lim4 != 0);
        e[0] = (lim3 == 0) ? 256 : int'(lim3);
        e[1] = (lim4 == 0) ? 256 : int'(lim4);
        r3   = on && r[2] && (m_cnt[0] >= e[0]);
        r4   = on && r[3] && (m_cnt[1] >= e[1]);
        w    = -1;
        if (r3) w = 2;
        else if (r4) w = 3;
        else begin
            for (int i = 0; i < 4; i++) begin
                int k;
                k = (m_ptr + i) % 4;
                if (w < 0 && r[k]) w = k;
            end
        end
        if (r3 && r4) tag = "R7 tie";
        else if (r3 || r4) tag = "R5 escalation";
        else if (w < 0) tag = "R10 idle";
        else if (!on) tag = "R3 rotation";
        else if (lim3 == 0 || lim4 == 0) tag = "R6 zero-as-256";
        else tag = "R4 loss counting";
        for (int c = 0; c < 2; c++) begin
            if (!on || !r[c+2] || w == c + 2) m_cnt[c] = 0;
            else if (w >= 0 && m_cnt[c] < e[c]) m_cnt[c]++;
        end
        if (w >= 0) m_ptr = (w + 1) % 4; // R9
        g = (w >= 0) ? 4'(1 << w) : 4'b0000;
    endtask

    task automatic step(input logic [3:0] r);
        string tag;
        @(negedge clk);
        req = r;
        model_step(r, m_exp, tag);
        @(posedge clk);
        #1;
        last_g = grant;
        check(tag, grant, m_exp, grant_vld, m_exp != 0);
    endtask

    task automatic do_reset(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        rst  = 1'b1;
        req  = '0;
        lim3 = a;
        lim4 = b;
        @(posedge clk);
        @(posedge clk);
        #1;
        check("R1 reset", grant, 4'b0000, grant_vld, 1'b0);
        m_ptr    = 0;
        m_cnt[0] = 0;
        m_cnt[1] = 0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] vals [5];
        int c3_wins;
        vals[0] = 8'd0; vals[1] = 8'd1; vals[2] = 8'd2; vals[3] = 8'd3; vals[4] = 8'd255;

        // R1: first grant after reset goes to channel 1.
        do_reset(8'd0, 8'd0);
        step(4'b1111);
        check("R1 first grant", last_g, 4'b0001, 1'b1, 1'b1);

        // R7: both limits 1, everyone requesting.
        do_reset(8'd1, 8'd1);
        step(4'b1111); check("R7 d1", last_g, 4'b0001, 1'b1, 1'b1);
        step(4'b1111); check("R7 d2 ch3 first", last_g, 4'b0100, 1'b1, 1'b1);
        step(4'b1111); check("R7 d3 ch4 keeps escalation", last_g, 4'b1000, 1'b1, 1'b1);

        // R8: dropping the request clears the count.
        do_reset(8'd2, 8'd0);
        step(4'b1111);
        step(4'b1001); check("R8 d2", last_g, 4'b1000, 1'b1, 1'b1);
        step(4'b1111); check("R8 d3", last_g, 4'b0001, 1'b1, 1'b1);
        step(4'b1111); check("R8 count cleared", last_g, 4'b0010, 1'b1, 1'b1);
        step(4'b1111); check("R8 d5 escalated", last_g, 4'b0100, 1'b1, 1'b1);

        // R9: pointer moves after an escalated grant.
        do_reset(8'd1, 8'd0);
        step(4'b1111);
        step(4'b1111); check("R9 escalated ch3", last_g, 4'b0100, 1'b1, 1'b1);
        step(4'b1111); check("R9 rotation after escalation", last_g, 4'b1000, 1'b1, 1'b1);

        // R10: idle keeps the rotation start.
        do_reset(8'd0, 8'd0);
        step(4'b0010);
        step(4'b0000); check("R10 no grant", last_g, 4'b0000, 1'b0, 1'b0);
        step(4'b1111); check("R10 pointer kept", last_g, 4'b0100, 1'b1, 1'b1);

        // R6: zero limit beside a non-zero one means 256 losses.
        do_reset(8'd0, 8'd1);
        c3_wins = 0;
        for (int k = 0; k < 256; k++) begin
            step(4'b1111);
            if (last_g[2]) c3_wins++;
        end
        checks++;
        if (c3_wins != 0) begin
            errors++;
            $display("FAIL R6: channel 3 won %0d times before 256 losses, expected 0", c3_wins);
        end
        step(4'b1111); check("R6 escalated at 256", last_g, 4'b0100, 1'b1, 1'b1);

        // Sweep of limit pairs and request patterns against the model (R2 R3 R4 R5).
        foreach (vals[a]) begin
            foreach (vals[b]) begin
                do_reset(vals[a], vals[b]);
                for (int r = 0; r < 16; r++) step(4'(r));
                for (int n = 0; n < 120; n++) begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    step(lfsr[3:0] | lfsr[7:4]);
                end
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule